// File: doc/BRIEF.md
# USB receive endpoint handshake controller

This block holds the receive-side state of up to three endpoints of a full-speed USB device function and decides the handshake returned for each OUT or SETUP data packet. Every endpoint has an 8-bit register made of a control-endpoint flag, the data toggle expected on the next packet, a 2-bit receive status and a 4-bit endpoint address. A decoded token opens a transaction: the token's endpoint number is matched against the address fields. The data packet that follows closes it, given its data PID (DATA0 or DATA1) and a CRC-good flag. The block answers ACK, NAK, STALL or nothing, and raises a correct-transfer pulse for a packet that was accepted.

Software reaches the registers through a simple write/read port. After each accepted packet the hardware parks the endpoint in NAK. Software then has time to consume the data, and it writes the status back to valid to accept the next packet. A SETUP token to a control endpoint resets the expected toggle to DATA0. A USB bus reset returns every register to its reset value, as the system reset does. Serial decoding, CRC computation and IN transfers lie outside the block.

Top module: `usb_rx_ep_ctrl`

## Requirements
- R1: After `rst`, endpoint slot 0 reads 0x80 and slots 1 and 2 read 0x00. `hs_valid` and `ctr_pulse` are 0. A read presents `cpu_rdata` one clock after `cpu_addr` is applied, and a slot number of 3 or above reads 0x00.
- R2: Register layout: bit 7 is the control flag, bit 6 the expected toggle (0 = DATA0, 1 = DATA1), bits 5:4 the receive status and bits 3:0 the endpoint address. Slot 0 always reads bit 7 as 1 and bits 3:0 as 0, whatever is written. Slots 1 and 2 store all eight written bits.
- R3: For a good-CRC packet in an open, matched transaction, the receive status picks the handshake. 00 (disabled) gives no handshake, 01 gives STALL, 10 gives NAK and 11 (valid) gives ACK. The handshake appears on `hs_valid`/`hs_code` in the clock after `pkt_valid`, with `hs_code` 00 = ACK, 01 = NAK, 10 = STALL.
- R4: A token is matched to the lowest-numbered slot whose address field equals `tok_ep`. A token with no match, or a packet with no token since the previous packet, gets no handshake and changes no register.
- R5: A SETUP token (`tok_setup`=1) matched to a slot with the control flag set clears that slot's toggle when the token is taken. A SETUP token matched to a slot with the control flag clear is ignored: no toggle change and no handshake for its packet.
- R6: In valid status, a good-CRC packet whose PID equals the expected toggle is acknowledged with ACK. The toggle inverts, the status becomes 10 (NAK), and `ctr_pulse` rises for one clock with `ctr_ep` set to the slot number.
- R7: In valid status, a good-CRC packet whose PID differs from the expected toggle gets ACK. The toggle and status stay unchanged, and `ctr_pulse` stays 0.
- R8: A packet with `pkt_crc_ok`=0 gets no handshake and leaves the toggle and status unchanged.
- R9: `bus_reset` returns all registers to their R1 values, discards an open transaction and clears `hs_valid` and `ctr_pulse` in the next clock.
- R10: When a CPU write and an accepted packet (R6) hit the same slot in the same clock, the hardware result sets bits 6:4 and the written value sets bits 7 and 3:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| bus_reset | input | 1 | Synchronous USB bus reset, returns registers to reset values |
| tok_valid | input | 1 | One-clock token event |
| tok_setup | input | 1 | Token type: 1 = SETUP, 0 = OUT |
| tok_ep | input | 4 | Endpoint number carried by the token |
| pkt_valid | input | 1 | One-clock end-of-data-packet event |
| pkt_data1 | input | 1 | Data PID of the packet: 1 = DATA1, 0 = DATA0 |
| pkt_crc_ok | input | 1 | Packet CRC was good |
| cpu_we | input | 1 | Register write strobe |
| cpu_addr | input | 2 | Register slot select |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Registered read data of the selected slot |
| hs_valid | output | 1 | A handshake is to be sent |
| hs_code | output | 2 | Handshake: 00 ACK, 01 NAK, 10 STALL |
| ctr_pulse | output | 1 | One-clock correct-transfer pulse |
| ctr_ep | output | 2 | Slot that completed the correct transfer |

## Verification
Two functions can land on the same endpoint in one clock: the CPU write port and the hardware update that follows an accepted packet. The bench provokes this on purpose. It raises `cpu_we` for the slot in the very clock that `pkt_valid` completes a matching-toggle packet there, and then reads the slot back. The read-back must show bits 7 and 3:0 from the write and the inverted toggle and NAK status from the hardware. Random traffic that mixes writes, tokens, packets and reads is checked against a bench model of every register.

// File: rtl/usb_rxep_pkg.sv
package usb_rxep_pkg;

  localparam int EPA_W = 4;

  typedef enum logic [1:0] {
    ST_OFF   = 2'b00,
    ST_STALL = 2'b01,
    ST_NAK   = 2'b10,
    ST_VALID = 2'b11
  } rx_stat_e;

  typedef enum logic [1:0] {
    HS_ACK   = 2'b00,
    HS_NAK   = 2'b01,
    HS_STALL = 2'b10
  } hs_code_e;

  typedef struct packed {
    logic             ctl;
    logic             tog;
    rx_stat_e         stat;
    logic [EPA_W-1:0] addr;
  } ep_reg_t;

  localparam int REG_W = $bits(ep_reg_t);

  localparam ep_reg_t EP0_RST = '{ctl: 1'b1, tog: 1'b0, stat: ST_OFF, addr: '0};
  localparam ep_reg_t EPN_RST = '{ctl: 1'b0, tog: 1'b0, stat: ST_OFF, addr: '0};

endpackage

// File: rtl/rxep_reg.sv
module rxep_reg
  import usb_rxep_pkg::*;
#(
  parameter bit FIXED_EP0 = 1'b0
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    bus_rst,
  input  logic    wr_en,
  input  ep_reg_t wr_val,
  input  logic    tog_clr,
  input  logic    xfer_ok,
  output ep_reg_t q
);

  localparam ep_reg_t RST_VAL = FIXED_EP0 ? EP0_RST : EPN_RST;

  ep_reg_t wr_fix;
  ep_reg_t d;

  // slot 0 keeps a fixed control flag and address
  always_comb begin
    wr_fix = wr_val;
    if (FIXED_EP0) begin
      wr_fix.ctl  = 1'b1;
      wr_fix.addr = '0;
    end
  end

  // software write first, then hardware result, then SETUP clear
  always_comb begin
    d = q;
    if (wr_en) d = wr_fix;
    if (xfer_ok) begin
      d.tog  = ~q.tog;
      d.stat = ST_NAK;
    end
    if (tog_clr) d.tog = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || bus_rst) q <= RST_VAL;
    else                q <= d;
  end

  // R6
  nak_after_ctr_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_ok && !bus_rst) |=> (q.stat == ST_NAK));

  // R10
  hw_wins_tog_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_ok && !bus_rst && !tog_clr) |=> (q.tog != $past(q.tog)));

  generate
    if (FIXED_EP0) begin : g_fix
      // R2
      ep0_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (q.ctl && (q.addr == '0)));
    end
  endgenerate

endmodule

// File: rtl/rxep_match.sv
module rxep_match
  import usb_rxep_pkg::*;
#(
  parameter int NUM_EP = 3,
  parameter int IDX_W  = 2
) (
  input  logic [EPA_W-1:0] addrs [NUM_EP],
  input  logic [EPA_W-1:0] ep,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);

  // scan downward so the lowest matching slot is left in idx
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NUM_EP - 1; i >= 0; i--) begin
      if (addrs[i] == ep) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/rxep_decide.sv
module rxep_decide
  import usb_rxep_pkg::*;
(
  input  logic     open_ok,
  input  logic     crc_ok,
  input  logic     pid1,
  input  logic     cur_tog,
  input  rx_stat_e cur_stat,
  output logic     hs_en,
  output hs_code_e code,
  output logic     xfer_ok
);

  always_comb begin
    hs_en   = 1'b0;
    code    = HS_ACK;
    xfer_ok = 1'b0;
    if (open_ok && crc_ok) begin
      unique case (cur_stat)
        ST_OFF: ;
        ST_STALL: begin
          hs_en = 1'b1;
          code  = HS_STALL;
        end
        ST_NAK: begin
          hs_en = 1'b1;
          code  = HS_NAK;
        end
        ST_VALID: begin
          hs_en   = 1'b1;
          code    = HS_ACK;
          xfer_ok = (pid1 == cur_tog);
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/usb_rx_ep_ctrl.sv
module usb_rx_ep_ctrl
  import usb_rxep_pkg::*;
#(
  parameter int NUM_EP = 3,
  parameter int IDX_W  = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_reset,
  input  logic             tok_valid,
  input  logic             tok_setup,
  input  logic [EPA_W-1:0] tok_ep,
  input  logic             pkt_valid,
  input  logic             pkt_data1,
  input  logic             pkt_crc_ok,
  input  logic             cpu_we,
  input  logic [IDX_W-1:0] cpu_addr,
  input  logic [REG_W-1:0] cpu_wdata,
  output logic [REG_W-1:0] cpu_rdata,
  output logic             hs_valid,
  output logic [1:0]       hs_code,
  output logic             ctr_pulse,
  output logic [IDX_W-1:0] ctr_ep
);

  ep_reg_t          regs  [NUM_EP];
  logic [EPA_W-1:0] addrs [NUM_EP];

  logic             m_hit;
  logic [IDX_W-1:0] m_idx;
  logic             m_ctl;
  logic             tok_accept;

  logic             txn_open;
  logic             txn_hit;
  logic [IDX_W-1:0] txn_idx;

  logic             cur_tog;
  rx_stat_e         cur_stat;
  logic             dec_hs;
  hs_code_e         dec_code;
  logic             dec_xfer;
  ep_reg_t          rd_val;

  // ---------------- endpoint match ----------------
  always_comb begin
    for (int i = 0; i < NUM_EP; i++) addrs[i] = regs[i].addr;
  end

  rxep_match #(.NUM_EP(NUM_EP), .IDX_W(IDX_W)) u_match (
    .addrs (addrs),
    .ep    (tok_ep),
    .hit   (m_hit),
    .idx   (m_idx)
  );

  always_comb begin
    m_ctl = 1'b0;
    for (int i = 0; i < NUM_EP; i++)
      if (m_idx == IDX_W'(i)) m_ctl = regs[i].ctl;
  end

  assign tok_accept = m_hit && (!tok_setup || m_ctl);

  // ---------------- transaction context ----------------
  always_ff @(posedge clk) begin
    if (rst || bus_reset) begin
      txn_open <= 1'b0;
      txn_hit  <= 1'b0;
      txn_idx  <= '0;
    end else if (tok_valid) begin
      txn_open <= 1'b1;
      txn_hit  <= tok_accept;
      txn_idx  <= m_idx;
    end else if (pkt_valid) begin
      txn_open <= 1'b0;
    end
  end

  always_comb begin
    cur_tog  = 1'b0;
    cur_stat = ST_OFF;
    for (int i = 0; i < NUM_EP; i++) begin
      if (txn_idx == IDX_W'(i)) begin
        cur_tog  = regs[i].tog;
        cur_stat = regs[i].stat;
      end
    end
  end

  // ---------------- handshake decision ----------------
  rxep_decide u_dec (
    .open_ok  (pkt_valid && txn_open && txn_hit),
    .crc_ok   (pkt_crc_ok),
    .pid1     (pkt_data1),
    .cur_tog  (cur_tog),
    .cur_stat (cur_stat),
    .hs_en    (dec_hs),
    .code     (dec_code),
    .xfer_ok  (dec_xfer)
  );

  // ---------------- endpoint registers ----------------
  generate
    for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
      rxep_reg #(.FIXED_EP0(g == 0)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .bus_rst (bus_reset),
        .wr_en   (cpu_we && (cpu_addr == IDX_W'(g))),
        .wr_val  (ep_reg_t'(cpu_wdata)),
        .tog_clr (tok_valid && tok_setup && tok_accept && (m_idx == IDX_W'(g))),
        .xfer_ok (dec_xfer && (txn_idx == IDX_W'(g))),
        .q       (regs[g])
      );
    end
  endgenerate

  // ---------------- registered outputs ----------------
  always_ff @(posedge clk) begin
    if (rst || bus_reset) begin
      hs_valid  <= 1'b0;
      hs_code   <= HS_ACK;
      ctr_pulse <= 1'b0;
      ctr_ep    <= '0;
    end else begin
      hs_valid  <= dec_hs;
      hs_code   <= dec_code;
      ctr_pulse <= dec_xfer;
      ctr_ep    <= txn_idx;
    end
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_EP; i++)
      if (cpu_addr == IDX_W'(i)) rd_val = regs[i];
  end

  always_ff @(posedge clk) begin
    if (rst) cpu_rdata <= '0;
    else     cpu_rdata <= rd_val;
  end

  // R3
  hs_code_legal_chk: assert property (@(posedge clk) disable iff (rst)
    hs_valid |-> (hs_code != 2'b11));

  // R3
  hs_after_pkt_chk: assert property (@(posedge clk) disable iff (rst)
    hs_valid |-> $past(pkt_valid));

  // R6
  ctr_implies_ack_chk: assert property (@(posedge clk) disable iff (rst)
    ctr_pulse |-> (hs_valid && hs_code == HS_ACK));

  // R9
  bus_reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(bus_reset) |-> (!hs_valid && !ctr_pulse));

  // R4
  no_txn_no_hs_chk: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && !txn_open && !bus_reset) |=> !hs_valid);

endmodule

// File: tb/sim_usb_rx_ep_ctrl.sv
module sim_usb_rx_ep_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_reset = 1'b0;
  logic       tok_valid = 1'b0, tok_setup = 1'b0;
  logic [3:0] tok_ep = '0;
  logic       pkt_valid = 1'b0, pkt_data1 = 1'b0, pkt_crc_ok = 1'b0;
  logic       cpu_we = 1'b0;
  logic [1:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic       hs_valid;
  logic [1:0] hs_code;
  logic       ctr_pulse;
  logic [1:0] ctr_ep;

  int checks = 0;
  int errors = 0;

  // bench model
  logic [7:0] m [3];
  bit         m_open = 0, m_hit = 0;
  int         m_idx = 0;

  always #4 clk = ~clk;

  usb_rx_ep_ctrl u0 (
    .clk(clk), .rst(rst), .bus_reset(bus_reset),
    .tok_valid(tok_valid), .tok_setup(tok_setup), .tok_ep(tok_ep),
    .pkt_valid(pkt_valid), .pkt_data1(pkt_data1), .pkt_crc_ok(pkt_crc_ok),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .hs_valid(hs_valid), .hs_code(hs_code),
    .ctr_pulse(ctr_pulse), .ctr_ep(ctr_ep)
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] fix(int i, logic [7:0] d);
    return (i == 0) ? {1'b1, d[6:4], 4'b0000} : d;
  endfunction

  function automatic int find(logic [3:0] ep);
    for (int i = 0; i < 3; i++) if (m[i][3:0] == ep) return i;
    return -1;
  endfunction

  task automatic model_reset();
    m[0] = 8'h80; m[1] = 8'h00; m[2] = 8'h00;
    m_open = 0; m_hit = 0; m_idx = 0;
  endtask

  task automatic wr(int i, logic [7:0] d);
    cpu_we = 1'b1; cpu_addr = 2'(i); cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
    if (i < 3) m[i] = fix(i, d);
  endtask

  task automatic rd(int i, string tag);
    logic [7:0] exp;
    exp = (i < 3) ? m[i] : 8'h00;
    cpu_addr = 2'(i);
    @(negedge clk);
    chk(cpu_rdata == exp, tag, cpu_rdata, exp);
  endtask

  task automatic tok(bit setup, logic [3:0] ep);
    int idx;
    tok_valid = 1'b1; tok_setup = setup; tok_ep = ep;
    idx = find(ep);
    m_open = 1;
    if (idx >= 0 && (!setup || m[idx][7])) begin
      m_hit = 1; m_idx = idx;
      if (setup) m[idx][6] = 1'b0;
    end else m_hit = 0;
    @(negedge clk);
    tok_valid = 1'b0;
  endtask

  // packet, optionally with a concurrent CPU write
  task automatic pkt(bit pid, bit crc, bit w, int wi, logic [7:0] wd, string tag);
    bit e_hs = 0, e_ctr = 0;
    logic [1:0] e_code = 2'b00;
    int e_idx = 0;
    logic [7:0] nv;
    if (m_open && m_hit && crc) begin
      case (m[m_idx][5:4])
        2'b01: begin e_hs = 1; e_code = 2'b10; end
        2'b10: begin e_hs = 1; e_code = 2'b01; end
        2'b11: begin
          e_hs = 1; e_code = 2'b00;
          if (pid == m[m_idx][6]) begin e_ctr = 1; e_idx = m_idx; end
        end
        default: ;
      endcase
    end
    pkt_valid = 1'b1; pkt_data1 = pid; pkt_crc_ok = crc;
    if (w) begin cpu_we = 1'b1; cpu_addr = 2'(wi); cpu_wdata = wd; end
    @(negedge clk);
    pkt_valid = 1'b0; cpu_we = 1'b0;
    m_open = 0;
    if (e_ctr) begin
      m[e_idx][6]   = ~m[e_idx][6];
      m[e_idx][5:4] = 2'b10;
    end
    if (w && wi < 3) begin
      nv = fix(wi, wd);
      if (e_ctr && wi == e_idx) m[wi] = {nv[7], m[wi][6:4], nv[3:0]};
      else m[wi] = nv;
    end
    chk({hs_valid, hs_valid ? hs_code : 2'b00} == {e_hs, e_code}, tag,
        {hs_valid, hs_code}, {e_hs, e_code});
    chk({ctr_pulse, ctr_pulse ? ctr_ep : 2'b00} == {e_ctr, e_ctr ? 2'(e_idx) : 2'b00},
        (tag == "R3") ? "R6" : tag, {ctr_pulse, ctr_ep}, {e_ctr, 2'(e_idx)});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(!hs_valid && !ctr_pulse, "R1", {hs_valid, ctr_pulse}, 0);
    for (int i = 0; i < 4; i++) rd(i, "R1");

    // R2 fixed fields of slot 0, full storage of others
    wr(0, 8'h3F); rd(0, "R2");
    chk(m[0] == 8'hB0, "R2", m[0], 8'hB0);
    wr(1, 8'hFF); rd(1, "R2");

    // R5 SETUP clears toggle; R6 accept
    wr(1, 8'h01);
    wr(0, 8'hF0);
    tok(1'b1, 4'h0); rd(0, "R5");
    pkt(1'b0, 1'b1, 0, 0, 0, "R6");
    rd(0, "R6");

    // R3 NAK, STALL, disabled
    tok(1'b0, 4'h0); pkt(1'b0, 1'b1, 0, 0, 0, "R3");
    wr(0, 8'h90); tok(1'b0, 4'h0); pkt(1'b1, 1'b1, 0, 0, 0, "R3");
    wr(0, 8'h80); tok(1'b0, 4'h0); pkt(1'b1, 1'b1, 0, 0, 0, "R3");

    // R7 duplicate packet
    wr(0, 8'hF0); tok(1'b0, 4'h0); pkt(1'b0, 1'b1, 0, 0, 0, "R7");
    rd(0, "R7");

    // R8 bad CRC
    tok(1'b0, 4'h0); pkt(1'b1, 1'b0, 0, 0, 0, "R8");
    rd(0, "R8");

    // R5 SETUP to non-control slot ignored
    wr(1, 8'h71); tok(1'b1, 4'h1); pkt(1'b0, 1'b1, 0, 0, 0, "R5");
    rd(1, "R5");

    // R4 priority, no match, no token
    wr(1, 8'h72); wr(2, 8'h32);
    tok(1'b0, 4'h2); pkt(1'b1, 1'b1, 0, 0, 0, "R4");
    rd(1, "R4"); rd(2, "R4");
    tok(1'b0, 4'h9); pkt(1'b0, 1'b1, 0, 0, 0, "R4");
    pkt(1'b0, 1'b1, 0, 0, 0, "R4");

    // R10 concurrent write and accepted packet
    wr(2, 8'h33); tok(1'b0, 4'h3);
    pkt(1'b0, 1'b1, 1, 2, 8'hC5, "R10");
    rd(2, "R10");
    chk(m[2] == 8'hE5, "R10", m[2], 8'hE5);

    // R9 bus reset drops open transaction and registers
    wr(1, 8'h31); tok(1'b0, 4'h1);
    bus_reset = 1'b1;
    @(negedge clk);
    bus_reset = 1'b0;
    model_reset();
    chk(!hs_valid && !ctr_pulse, "R9", {hs_valid, ctr_pulse}, 0);
    pkt(1'b0, 1'b1, 0, 0, 0, "R9");
    for (int i = 0; i < 3; i++) rd(i, "R9");

    // random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      int op;
      op = $urandom % 8;
      case (op)
        0, 1: begin
          int wi;
          logic [7:0] d;
          wi = $urandom % 4;
          d  = 8'($urandom);
          d[3:0] = 4'($urandom % 4);
          wr(wi, d);
        end
        2, 3: tok(1'($urandom), 4'($urandom % 4));
        4, 5: pkt(1'($urandom), ($urandom % 8) != 0, 0, 0, 0, "R3");
        6: begin
          int wi;
          logic [7:0] d;
          wi = $urandom % 3;
          d  = 8'($urandom);
          d[3:0] = 4'($urandom % 4);
          pkt(1'($urandom), 1'b1, 1, wi, d, "R10");
        end
        default: rd($urandom % 4, "R2");
      endcase
    end
    for (int i = 0; i < 3; i++) rd(i, "R6");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule